// File: doc/BRIEF.md
# Boundary-aligned word deserializer

This block sits behind the serial receiver of a bidirectional parallel-to-serial link. Every frame on the serial side carries 24 data bits and then a two-bit boundary pattern. The pattern is flagged by a marker input and can only appear at the edge of a word. The block counts data bits between boundaries and declares alignment once two boundaries arrive exactly one frame apart. It then reassembles each aligned frame into a 24-bit word and drives it onto a parallel output, with a one-cycle word-clock pulse for each accepted word.

A two-bit mode input selects which parallel bits the receiver may write. The mode also selects the per-bit output enables and whether the two top serial bits are remapped onto the two top outputs. A direction input reports when the device is transmitting. While it is high, the receiver is idle, the word clock is held high and the shared parallel pins are released. Pins that are dedicated outputs keep the last value that was written to them.

Top module: `wd_deser`

## Requirements
- R1: A bit is taken only on a clock where `bit_en` is 1. A data bit has `bnd_mark` 0, and the 24 data bits of a frame fill `par_out[0]` first through `par_out[23]` last. A boundary is two consecutive taken bits with `bnd_mark` 1, carrying the values 1 and then 0.
- R2: Alignment is reached when a boundary follows the previous boundary after exactly 24 data bits. The frame between those two boundaries is accepted. A boundary that follows no earlier valid boundary produces no word.
- R3: Any of the following breaks alignment and produces no word: a boundary after fewer than 24 data bits, a 25th data bit, or a marked bit that does not fit the 1-then-0 pattern. After a break, the next complete boundary counts only as the first of a new pair.
- R4: `word_clk` is 1 for exactly one clock, in the cycle after the edge that samples the second boundary bit of an accepted frame. `par_out` takes the new word in that same cycle.
- R5: In mode 2'b01, an accepted word writes all 24 outputs, and `par_oe` is all ones while receiving.
- R6: In mode 2'b10, an accepted word writes only `par_out[19:0]`. Bits 23:20 keep their values and have `par_oe` 0.
- R7: In mode 2'b11, an accepted word writes `par_out[19:0]` from data bits 0–19, and writes `par_out[23:22]` from data bits 21:20. `par_out[21:20]` keep their values and have `par_oe` 0. `par_oe[23:22]` is 1.
- R8: While `ser_act` is 1 and the mode is not 2'b00, the following hold. `word_clk` is 1 and `par_oe[19:0]` is 0. Incoming bits are ignored and `par_out` holds. The dedicated output enables follow the mode. Alignment is discarded, so after `ser_act` falls two boundaries are needed again.
- R9: In mode 2'b00, the following hold. `par_out` clears to zero one clock later, `par_oe` is 0 and `word_clk` is 0. Alignment is discarded.
- R10: An active-low `rst_n` clears `par_out` and `word_clk` at once and discards alignment. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pin-usage mode: 00 off, 01 all outputs, 10 top four inputs, 11 split pair |
| ser_act | input | 1 | High while the device transmits |
| bit_en | input | 1 | Qualifies the serial bit on this clock |
| ser_bit | input | 1 | Received serial data bit |
| bnd_mark | input | 1 | Flags a boundary bit slot |
| par_out | output | 24 | Parallel word output |
| par_oe | output | 24 | Per-bit output enable |
| word_clk | output | 1 | Word strobe |

## Verification
The bench sends frames with random gaps between qualified bits and random values on the idle inputs. It aims at several break cases: a boundary one data bit early, a 25th data bit, and a malformed marker in the middle of a frame. A receiver that trusted a lone boundary would emit garbage words after such breaks. A receiver that needed more than one fresh boundary would drop a good word. Mode switches check that the protected fields keep an older word's bits. A mapping error would overwrite the top pair or shift it. The transmit and off phases confirm that a receiver left armed would strobe a word after turnaround, and that a missing clear would leak stale data.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int WORD_BITS = 24;
  localparam int SHARED_BITS = 20;

  typedef enum logic [1:0] {
    MD_OFF     = 2'd0,
    MD_FULL    = 2'd1,
    MD_QUAD_IN = 2'd2,
    MD_PAIR    = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    SY_HUNT = 2'd0,
    SY_CAND = 2'd1,
    SY_LOCK = 2'd2
  } sync_t;
endpackage

// File: rtl/wd_rst_sync.sv
module wd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/wd_frame_sync.sv
module wd_frame_sync
  import wd_pkg::*;
#(
  parameter int DATA_W = WORD_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  input  logic ser_bit,
  input  logic mark,
  output logic take,
  output logic word_ok
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DATA_W);

  sync_t          st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           half_q, half_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    half_n  = half_q;
    take    = 1'b0;
    word_ok = 1'b0;
    if (clr) begin
      st_n   = SY_HUNT;
      cnt_n  = '0;
      half_n = 1'b0;
    end else if (bit_en) begin
      if (mark) begin
        if (ser_bit && !half_q) begin
          half_n = 1'b1;
        end else if (!ser_bit && half_q) begin
          half_n = 1'b0;
          cnt_n  = '0;
          if (st_q == SY_HUNT) begin
            st_n = SY_CAND;
          end else if (cnt_q == FULL_CNT) begin
            st_n    = SY_LOCK;
            word_ok = 1'b1;
          end else begin
            st_n = SY_CAND;
          end
        end else begin
          half_n = 1'b0;
          st_n   = SY_HUNT;
          cnt_n  = '0;
        end
      end else if (half_q || cnt_q == FULL_CNT) begin
        half_n = 1'b0;
        st_n   = SY_HUNT;
        cnt_n  = '0;
      end else begin
        take  = 1'b1;
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SY_HUNT;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      half_q <= half_n;
    end
  end

  // R3: a data bit beyond a full frame loses alignment
  p_overrun_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_en && !mark && cnt_q == FULL_CNT) |=> (st_q == SY_HUNT));

  // R2: an accepted word leaves the receiver aligned at frame start
  p_word_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |=> (st_q == SY_LOCK && cnt_q == '0));

  // R8 / R9: clearing discards alignment
  p_clear_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == SY_HUNT && !half_q));
endmodule

// File: rtl/wd_shift.sv
module wd_shift #(
  parameter int DATA_W = wd_pkg::WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sh_q, sh_n;

  always_comb sh_n = {din, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (take) sh_q <= sh_n;
  end

  assign word = sh_q;
endmodule

// File: rtl/wd_out_map.sv
module wd_out_map
  import wd_pkg::*;
#(
  parameter int DATA_W  = WORD_BITS,
  parameter int SHARE_W = SHARED_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              ser_act,
  input  logic              ok,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] par_out,
  output logic [DATA_W-1:0] par_oe,
  output logic              pulse
);
  localparam int CTL_W  = DATA_W - SHARE_W;
  localparam int PAIR_W = CTL_W / 2;

  logic              live;
  logic [DATA_W-1:0] wr_v, src_v, par_q, par_n;
  logic              pulse_q, upd;

  assign live = (mode != MD_OFF);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < SHARE_W) begin : g_shared
      assign wr_v[i]   = 1'b1;
      assign src_v[i]  = word[i];
      assign par_oe[i] = live & ~ser_act;
    end else if (i < SHARE_W + PAIR_W) begin : g_low_ctl
      assign wr_v[i]   = (mode == MD_FULL);
      assign src_v[i]  = word[i];
      assign par_oe[i] = (mode == MD_FULL);
    end else begin : g_high_ctl
      assign wr_v[i]   = (mode == MD_FULL) | (mode == MD_PAIR);
      assign src_v[i]  = (mode == MD_PAIR) ? word[i-PAIR_W] : word[i];
      assign par_oe[i] = (mode == MD_FULL) | (mode == MD_PAIR);
    end
  end

  always_comb begin
    upd = ~live | ok;
    if (!live) par_n = '0;
    else       par_n = (wr_v & src_v) | (~wr_v & par_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= ok;
      if (upd) par_q <= par_n;
    end
  end

  assign par_out = par_q;
  assign pulse   = pulse_q;

  // R4: the strobe never lasts two cycles
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R8: while transmitting the outputs hold
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_act && live) |=> $stable(par_q));

  // R9: the off mode clears outputs and strobe
  p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (par_q == '0 && !pulse_q));

  // R6: top control bits are inputs and keep their value
  p_quad_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_QUAD_IN) |=> $stable(par_q[DATA_W-1:SHARE_W]));

  // R7: the low control pair keeps its value
  p_pair_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PAIR) |=> $stable(par_q[SHARE_W+PAIR_W-1:SHARE_W]));
endmodule

// File: rtl/wd_deser.sv
module wd_deser
  import wd_pkg::*;
#(
  parameter int DATA_W  = WORD_BITS,
  parameter int SHARE_W = SHARED_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              ser_act,
  input  logic              bit_en,
  input  logic              ser_bit,
  input  logic              bnd_mark,
  output logic [DATA_W-1:0] par_out,
  output logic [DATA_W-1:0] par_oe,
  output logic              word_clk
);
  mode_t             mode_e;
  logic              rst_sn, clr, take, word_ok, pulse;
  logic [DATA_W-1:0] word;

  assign mode_e = mode_t'(mode);
  assign clr    = (mode_e == MD_OFF) | ser_act;

  wd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  wd_frame_sync #(.DATA_W(DATA_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (clr),
    .bit_en  (bit_en),
    .ser_bit (ser_bit),
    .mark    (bnd_mark),
    .take    (take),
    .word_ok (word_ok)
  );

  wd_shift #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_sn),
    .take  (take),
    .din   (ser_bit),
    .word  (word)
  );

  wd_out_map #(.DATA_W(DATA_W), .SHARE_W(SHARE_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_sn),
    .mode    (mode_e),
    .ser_act (ser_act),
    .ok      (word_ok),
    .word    (word),
    .par_out (par_out),
    .par_oe  (par_oe),
    .pulse   (pulse)
  );

  assign word_clk = pulse | (ser_act & (mode_e != MD_OFF));

  // R8: no word is accepted while transmitting
  p_tx_no_word_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ser_act |=> !pulse);
endmodule

// File: tb/tb_wd_deser.sv
`timescale 1ns/1ps
module tb_wd_deser;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        ser_act, bit_en, ser_bit, bnd_mark;
  logic [23:0] par_out, par_oe;
  logic        word_clk;

  int          checks = 0;
  int          errors = 0;
  logic [23:0] exp_par;

  always #2 clk = ~clk;

  wd_deser dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ser_act(ser_act),
    .bit_en(bit_en), .ser_bit(ser_bit), .bnd_mark(bnd_mark),
    .par_out(par_out), .par_oe(par_oe), .word_clk(word_clk)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] map_word(input logic [23:0] prev, input logic [23:0] w,
                                           input logic [1:0] md);
    logic [23:0] r;
    r = prev;
    r[19:0] = w[19:0];
    if (md == 2'd1) r[23:20] = w[23:20];
    if (md == 2'd3) r[23:22] = w[21:20];
    return r;
  endfunction

  function automatic logic [23:0] exp_oe(input logic [1:0] md, input logic sa);
    logic [23:0] r;
    r = '0;
    if (md != 2'd0) begin
      r[19:0]  = sa ? 20'h0 : 20'hFFFFF;
      r[21:20] = (md == 2'd1) ? 2'b11 : 2'b00;
      r[23:22] = (md == 2'd1 || md == 2'd3) ? 2'b11 : 2'b00;
    end
    return r;
  endfunction

  task automatic send_bit(input logic b, input logic m);
    int gap;
    gap = $urandom_range(0, 2);
    repeat (gap) @(negedge clk);
    bit_en = 1'b1; ser_bit = b; bnd_mark = m;
    @(negedge clk);
    bit_en = 1'b0; ser_bit = 1'($urandom()); bnd_mark = 1'($urandom());
  endtask

  task automatic send_bnd();
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b1);
  endtask

  task automatic frame_expect(input logic [23:0] w, input int n, input bit emit, input string tag);
    logic [23:0] idle_clk;
    for (int i = 0; i < n; i++) send_bit((i < 24) ? w[i] : 1'b0, 1'b0);
    send_bnd();
    idle_clk = {23'd0, (ser_act && mode != 2'd0)};
    if (emit) begin
      exp_par = map_word(exp_par, w, mode);
      chk({tag, " word_clk pulse R4"}, {23'd0, word_clk}, 24'd1);
      chk({tag, " par_out"}, par_out, exp_par);
      @(negedge clk);
      chk({tag, " word_clk single R4"}, {23'd0, word_clk}, 24'd0);
    end else begin
      chk({tag, " no word_clk"}, {23'd0, word_clk}, idle_clk);
      chk({tag, " par_out held"}, par_out, exp_par);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 24'd0, 24'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'd1357));
    rst_n = 1'b0; mode = 2'd1; ser_act = 1'b0;
    bit_en = 1'b0; ser_bit = 1'b0; bnd_mark = 1'b0;
    exp_par = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 reset par_out", par_out, 24'd0);
    chk("R10 reset word_clk", {23'd0, word_clk}, 24'd0);
    chk("R5 oe mode1", par_oe, exp_oe(2'd1, 1'b0));

    // R2 lone boundary emits nothing
    send_bnd();
    chk("R2 first boundary no word", {23'd0, word_clk}, 24'd0);
    // R1 bit order
    frame_expect(24'h000001, 24, 1, "R1 lsb first");
    frame_expect(24'h800000, 24, 1, "R1 msb last");
    // R5 random words in mode 1
    for (int k = 0; k < 6; k++) frame_expect(24'($urandom()), 24, 1, "R5 random");

    // R3 early boundary
    frame_expect(24'($urandom()), 23, 0, "R3 short frame");
    frame_expect(24'($urandom()), 24, 1, "R3 resync after short");
    // R3 overrun
    frame_expect(24'($urandom()), 25, 0, "R3 long frame");
    frame_expect(24'($urandom()), 24, 1, "R3 resync after long");
    // R3 malformed marker mid frame
    w = 24'($urandom());
    for (int i = 0; i < 10; i++) send_bit(w[i], 1'b0);
    send_bit(1'b0, 1'b1);
    frame_expect(w, 14, 0, "R3 bad marker");
    frame_expect(24'($urandom()), 24, 1, "R3 resync after marker");

    // R6 mode 2
    mode = 2'd2;
    @(negedge clk);
    chk("R6 oe mode2", par_oe, exp_oe(2'd2, 1'b0));
    for (int k = 0; k < 4; k++) frame_expect(24'($urandom()), 24, 1, "R6 quad-in");

    // R7 mode 3
    mode = 2'd1;
    frame_expect(24'hFFFFFF, 24, 1, "R5 preload");
    mode = 2'd3;
    @(negedge clk);
    chk("R7 oe mode3", par_oe, exp_oe(2'd3, 1'b0));
    frame_expect(24'h100000, 24, 1, "R7 pair remap low");
    frame_expect(24'h200000, 24, 1, "R7 pair remap high");
    for (int k = 0; k < 4; k++) frame_expect(24'($urandom()), 24, 1, "R7 random");

    // R8 transmit direction
    ser_act = 1'b1;
    @(negedge clk);
    chk("R8 word_clk high", {23'd0, word_clk}, 24'd1);
    chk("R8 oe tx", par_oe, exp_oe(2'd3, 1'b1));
    send_bnd();
    frame_expect(24'($urandom()), 24, 0, "R8 tx ignores bits");
    ser_act = 1'b0;
    @(negedge clk);
    chk("R8 oe back", par_oe, exp_oe(2'd3, 1'b0));
    frame_expect(24'($urandom()), 24, 0, "R8 needs new pair");
    frame_expect(24'($urandom()), 24, 1, "R8 resumed");

    // R9 off mode
    mode = 2'd0;
    @(negedge clk);
    exp_par = '0;
    chk("R9 par_out cleared", par_out, 24'd0);
    chk("R9 oe off", par_oe, 24'd0);
    frame_expect(24'($urandom()), 24, 0, "R9 off ignores");
    mode = 2'd1;
    frame_expect(24'($urandom()), 24, 0, "R9 needs new pair");
    frame_expect(24'($urandom()), 24, 1, "R9 resumed");

    // R10 reset mid run
    rst_n = 1'b0;
    @(negedge clk);
    exp_par = '0;
    chk("R10 async clear", par_out, 24'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame_expect(24'($urandom()), 24, 0, "R10 needs new pair");
    frame_expect(24'($urandom()), 24, 1, "R10 resumed");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule